// File: doc/BRIEF.md
# Programmable Periodic Tick Interrupt Unit

This block produces a periodic interrupt from a 32768 Hz time base, in the way a real-time-clock device does. A host reaches its registers through two byte-wide ports. A write to the index port chooses a register. A later access at the data port reads or writes the chosen register. Three registers are decoded:

- A control register at index 0x0A. It holds a three-bit divider-chain field and a four-bit rate code.
- A mode register at index 0x0B. It holds the interrupt enables.
- A read-only flag register at index 0x0C. It shows the pending interrupt sources.

The time base enters as a one-cycle enable strobe, `tick_32k`, in the system clock domain. A free-running prescaler counts these strobes while the divider field holds the run value. The rate code picks a power-of-two tap of that prescaler. On each selected tick the periodic flag is set. When the periodic enable is on, the summary flag and the `irq` output rise and stay high until the host reads the flag register. That read returns the flags and clears them.

Top module: `rtc_tick_unit`

## Requirements
- R1: Writing the index port (`bus_port`=0) stores the low seven bits of `bus_wdata` as the selected index. A data-port write (`bus_port`=1) to index 0x0A stores bits 6:0, and bit 7 always reads 0. A data-port write to index 0x0B stores all eight bits. A data-port read puts the selected register on `bus_rdata` one clock later.
- R2: After a synchronous reset, the control register, the mode register and all flags read 0x00, and `irq` is low.
- R3: Writes to index 0x0C have no effect on the flags. Any index other than 0x0A, 0x0B or 0x0C reads 0x00 and ignores writes.
- R4: Ticks occur only while control bits 6:4 equal 3'b010. With any other value, the prescaler is held at zero and no flag is set.
- R5: For a rate code c from 3 to 15, the tick period is 2^(c-1) strobes. Code 1 gives 128 strobes and code 2 gives 256 strobes. After the run value is written, the first tick falls on strobe number equal to the period.
- R6: Rate code 0 produces no ticks.
- R7: Flag register bit 6 (periodic flag) is set on every tick, whatever the value of the enables.
- R8: When mode bit 6 (periodic enable) is 1 and the periodic flag is set, flag bit 7 and `irq` go high. They stay high through later ticks until index 0x0C is read. That read returns the flags as they were before the read and clears them.
- R9: If a tick and a read of index 0x0C fall in the same cycle, the read returns the old flags and the new tick's flag remains set afterwards.
- R10: A rewrite of the rate code while running does not reset the prescaler. The next tick falls at the next all-ones point of the new tap.
- R11: Flag bit 4 (update-ended placeholder) and flag bits 5 and 3:0 always read 0.
- R12: Setting the periodic enable while the periodic flag is already pending raises `irq` within two clocks of the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_32k | input | 1 | One-cycle enable strobe at 32768 Hz |
| bus_en | input | 1 | Host access valid this cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_port | input | 1 | 0 = index port, 1 = data port |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Registered read data from the data port |
| irq | output | 1 | Interrupt request, held until acknowledged |

## Verification
The hardest case to reach is a flag-register read that lands in exactly the same clock as a tick. If the clear wins, that tick is silently lost.

The bench reaches this case as follows:
- It restarts the prescaler by writing a stopped divider and then the run value.
- It issues one strobe fewer than the period.
- In a single cycle, it asserts the strobe and the data-port read together.

A second read then shows whether the flag survived. The rate switch is treated the same way: the prescaler position at the moment of the rewrite is known from the strobe count.

// File: rtl/rtc_tick_pkg.sv
package rtc_tick_pkg;
  localparam logic [7:0] IDX_CTRL  = 8'h0A;
  localparam logic [7:0] IDX_MODE  = 8'h0B;
  localparam logic [7:0] IDX_FLAGS = 8'h0C;

  localparam logic [2:0] DIV_RUN = 3'b010;

  localparam int MODE_PIE = 6;
  localparam int MODE_UIE = 4;

  localparam int FLG_IRQ = 7;
  localparam int FLG_PER = 6;
  localparam int FLG_UPD = 4;
endpackage

// File: rtl/rtc_host_if.sv
module rtc_host_if
  import rtc_tick_pkg::*;
#(
  parameter int IDX_W = 7,
  parameter int DW    = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          bus_en,
  input  logic          bus_we,
  input  logic          bus_port,
  input  logic [DW-1:0] bus_wdata,
  input  logic [DW-1:0] flags,
  output logic [DW-1:0] rdata,
  output logic [2:0]    div_sel,
  output logic [3:0]    rate,
  output logic          pie,
  output logic          uie,
  output logic          flag_ack
);
  logic [IDX_W-1:0] idx_q;
  logic [6:0]       ctrl_q;
  logic [DW-1:0]    mode_q;
  logic [DW-1:0]    rd_mux;
  logic             data_rd, data_wr, idx_wr;
  logic             hit_ctrl, hit_mode, hit_flags;

  assign idx_wr  = bus_en & ~bus_port & bus_we;
  assign data_wr = bus_en &  bus_port & bus_we;
  assign data_rd = bus_en &  bus_port & ~bus_we;

  assign hit_ctrl  = (idx_q == IDX_CTRL[IDX_W-1:0]);
  assign hit_mode  = (idx_q == IDX_MODE[IDX_W-1:0]);
  assign hit_flags = (idx_q == IDX_FLAGS[IDX_W-1:0]);

  always_comb begin
    rd_mux = '0;
    if (hit_ctrl)       rd_mux = {1'b0, ctrl_q};
    else if (hit_mode)  rd_mux = mode_q;
    else if (hit_flags) rd_mux = flags;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      idx_q  <= '0;
      ctrl_q <= '0;
      mode_q <= '0;
      rdata  <= '0;
    end else begin
      if (idx_wr) idx_q <= bus_wdata[IDX_W-1:0];
      if (data_wr && hit_ctrl) ctrl_q <= bus_wdata[6:0];
      if (data_wr && hit_mode) mode_q <= bus_wdata;
      if (data_rd) rdata <= rd_mux;
    end
  end

  assign flag_ack = data_rd & hit_flags;
  assign div_sel  = ctrl_q[6:4];
  assign rate     = ctrl_q[3:0];
  assign pie      = mode_q[MODE_PIE];
  assign uie      = mode_q[MODE_UIE];
endmodule

// File: rtl/rtc_rate_div.sv
module rtc_rate_div
  import rtc_tick_pkg::*;
#(
  parameter int CNT_W = 15
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       strobe,
  input  logic [2:0] div_sel,
  input  logic [3:0] rate,
  output logic       tick
);
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] mask;
  logic [3:0]       tap;
  logic             run;

  assign run = (div_sel == DIV_RUN);

  always_comb begin
    case (rate)
      4'd0:    tap = 4'd0;
      4'd1:    tap = 4'd7;
      4'd2:    tap = 4'd8;
      default: tap = rate - 4'd1;
    endcase
  end

  for (genvar g = 0; g < CNT_W; g++) begin : g_mask
    assign mask[g] = ({28'd0, tap} > 32'(g));
  end

  always_ff @(posedge clk) begin
    if (rst || !run) cnt_q <= '0;
    else if (strobe) cnt_q <= cnt_q + 1'b1;
  end

  assign tick = run & strobe & (tap != 4'd0) & ((cnt_q & mask) == mask);
endmodule

// File: rtl/rtc_flag_ctl.sv
module rtc_flag_ctl
  import rtc_tick_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       tick,
  input  logic       ack,
  input  logic       pie,
  input  logic       uie,
  output logic [7:0] flags,
  output logic       irq
);
  logic per_q, upd_q, irq_q;
  logic per_n, upd_n, irq_n;

  assign per_n = (per_q & ~ack) | tick;
  assign upd_n = upd_q & ~ack;
  assign irq_n = (irq_q & ~ack) | (per_n & pie) | (upd_n & uie);

  always_ff @(posedge clk) begin
    if (rst) begin
      per_q <= 1'b0;
      upd_q <= 1'b0;
      irq_q <= 1'b0;
    end else begin
      per_q <= per_n;
      upd_q <= upd_n;
      irq_q <= irq_n;
    end
  end

  always_comb begin
    flags          = '0;
    flags[FLG_IRQ] = irq_q;
    flags[FLG_PER] = per_q;
    flags[FLG_UPD] = upd_q;
  end

  assign irq = irq_q;
endmodule

// File: rtl/rtc_tick_unit.sv
module rtc_tick_unit
  import rtc_tick_pkg::*;
#(
  parameter int IDX_W = 7,
  parameter int CNT_W = 15
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       tick_32k,
  input  logic       bus_en,
  input  logic       bus_we,
  input  logic       bus_port,
  input  logic [7:0] bus_wdata,
  output logic [7:0] bus_rdata,
  output logic       irq
);
  logic [7:0] flags_w;
  logic [2:0] div_sel_w;
  logic [3:0] rate_w;
  logic       pie_w, uie_w, ack_w, tick_w;

  rtc_host_if #(.IDX_W(IDX_W), .DW(8)) u_host (
    .clk(clk), .rst(rst), .bus_en(bus_en), .bus_we(bus_we),
    .bus_port(bus_port), .bus_wdata(bus_wdata), .flags(flags_w),
    .rdata(bus_rdata), .div_sel(div_sel_w), .rate(rate_w),
    .pie(pie_w), .uie(uie_w), .flag_ack(ack_w)
  );

  rtc_rate_div #(.CNT_W(CNT_W)) u_div (
    .clk(clk), .rst(rst), .strobe(tick_32k), .div_sel(div_sel_w),
    .rate(rate_w), .tick(tick_w)
  );

  rtc_flag_ctl u_flag (
    .clk(clk), .rst(rst), .tick(tick_w), .ack(ack_w), .pie(pie_w),
    .uie(uie_w), .flags(flags_w), .irq(irq)
  );
endmodule

// File: rtl/rtc_tick_checker.sv
module rtc_tick_checker (
  input logic       clk,
  input logic       rst,
  input logic       irq,
  input logic       tick,
  input logic       ack,
  input logic       pie,
  input logic [7:0] flags,
  input logic [2:0] div_sel
);
  // R7: every tick leaves the periodic flag set
  a_r7_tick_sets_flag: assert property (@(posedge clk) disable iff (rst)
    tick |=> flags[6]);

  // R8: irq is held until the flag register is read
  a_r8_irq_held: assert property (@(posedge clk) disable iff (rst)
    irq && !ack |=> irq);

  // R8: irq only ever rises with the periodic enable on
  a_r8_rise_needs_enable: assert property (@(posedge clk) disable iff (rst)
    $rose(irq) |-> $past(pie));

  // R8: a read without a coincident tick clears flags and irq
  a_r8_ack_clears: assert property (@(posedge clk) disable iff (rst)
    ack && !tick |=> !flags[6] && !irq);

  // R9: a coincident tick survives the clearing read
  a_r9_tick_beats_ack: assert property (@(posedge clk) disable iff (rst)
    ack && tick |=> flags[6]);

  // R4: no tick without the run divider value
  a_r4_no_tick_stopped: assert property (@(posedge clk) disable iff (rst)
    (div_sel != 3'b010) |-> !tick);

  // R11: placeholder and unused flag bits stay zero
  a_r11_spare_bits_zero: assert property (@(posedge clk) disable iff (rst)
    flags[5:0] == 6'd0);
endmodule

bind rtc_tick_unit rtc_tick_checker u_chk (
  .clk(clk), .rst(rst), .irq(irq), .tick(tick_w), .ack(ack_w),
  .pie(pie_w), .flags(flags_w), .div_sel(div_sel_w)
);

// File: tb/sim_rtc_tick_unit.sv
module sim_rtc_tick_unit;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       tick_32k = 1'b0;
  logic       bus_en = 1'b0;
  logic       bus_we = 1'b0;
  logic       bus_port = 1'b0;
  logic [7:0] bus_wdata = 8'h00;
  logic [7:0] bus_rdata;
  logic       irq;

  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  rtc_tick_unit u0 (
    .clk(clk), .rst(rst), .tick_32k(tick_32k), .bus_en(bus_en),
    .bus_we(bus_we), .bus_port(bus_port), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .irq(irq)
  );

  task automatic check(input string tag, input logic [7:0] got, input logic [7:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %02h expected %02h", tag, got, exp);
    end
  endtask

  task automatic bus(input logic we, input logic port, input logic [7:0] d);
    @(negedge clk);
    bus_en = 1'b1; bus_we = we; bus_port = port; bus_wdata = d;
    @(negedge clk);
    bus_en = 1'b0; bus_we = 1'b0;
  endtask

  task automatic wr_reg(input logic [7:0] idx, input logic [7:0] v);
    bus(1'b1, 1'b0, idx);
    bus(1'b1, 1'b1, v);
  endtask

  task automatic rd_reg(input logic [7:0] idx, output logic [7:0] v);
    bus(1'b1, 1'b0, idx);
    bus(1'b0, 1'b1, 8'h00);
    v = bus_rdata;
  endtask

  task automatic strobes(input int n);
    if (n > 0) begin
      @(negedge clk);
      tick_32k = 1'b1;
      repeat (n) @(negedge clk);
      tick_32k = 1'b0;
    end
  endtask

  // restart prescaler with the given rate code
  task automatic restart(input logic [3:0] code);
    logic [7:0] dummy;
    wr_reg(8'h0A, {4'h0, code});
    wr_reg(8'h0A, {4'h2, code});
    rd_reg(8'h0C, dummy);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [7:0] v;
    repeat (3) @(negedge clk);
    rst = 1'b0;

    // R2 reset state
    check("R2 irq", {7'd0, irq}, 8'h00);
    rd_reg(8'h0A, v); check("R2 ctrl", v, 8'h00);
    rd_reg(8'h0B, v); check("R2 mode", v, 8'h00);
    rd_reg(8'h0C, v); check("R2 flags", v, 8'h00);

    // R1 register access
    wr_reg(8'h0A, 8'hFF); rd_reg(8'h0A, v); check("R1 ctrl bit7 reads 0", v, 8'h7F);
    wr_reg(8'h0B, 8'hC2); rd_reg(8'h0B, v); check("R1 mode", v, 8'hC2);
    wr_reg(8'h0B, 8'h00);

    // R3 read-only flags and unmapped index
    wr_reg(8'h0C, 8'hFF); rd_reg(8'h0C, v); check("R3 flags write ignored", v, 8'h00);
    wr_reg(8'h20, 8'h55); rd_reg(8'h20, v); check("R3 unmapped reads 0", v, 8'h00);
    rd_reg(8'h0A, v); check("R3 ctrl untouched", v, 8'h7F);

    // R5 / R7 / R11 sweep over all rate codes
    for (int c = 1; c < 16; c++) begin
      int k;
      k = (c == 1) ? 7 : (c == 2) ? 8 : c - 1;
      restart(4'(c));
      strobes((1 << k) - 1);
      rd_reg(8'h0C, v); check($sformatf("R5 code %0d before period", c), v, 8'h00);
      strobes(1);
      rd_reg(8'h0C, v); check($sformatf("R5 R7 R11 code %0d at period", c), v, 8'h40);
      if (c <= 4) begin
        strobes(1 << k);
        rd_reg(8'h0C, v); check($sformatf("R5 code %0d second period", c), v, 8'h40);
      end
    end

    // R4 wrong divider values
    wr_reg(8'h0A, 8'h33); strobes(64);
    rd_reg(8'h0C, v); check("R4 divider 011 no tick", v, 8'h00);
    wr_reg(8'h0A, 8'h03); strobes(64);
    rd_reg(8'h0C, v); check("R4 divider 000 no tick", v, 8'h00);

    // R6 rate code 0
    restart(4'h0); strobes(300);
    rd_reg(8'h0C, v); check("R6 code 0 no tick", v, 8'h00);

    // R8 irq set, held, cleared
    wr_reg(8'h0B, 8'h40);
    restart(4'h3);
    strobes(4);
    check("R8 irq raised", {7'd0, irq}, 8'h01);
    repeat (10) @(negedge clk);
    strobes(4);
    check("R8 irq held", {7'd0, irq}, 8'h01);
    rd_reg(8'h0C, v); check("R8 flags read", v, 8'hC0);
    check("R8 irq cleared", {7'd0, irq}, 8'h00);
    rd_reg(8'h0C, v); check("R8 flags cleared", v, 8'h00);

    // R9 tick coincides with the clearing read
    restart(4'h3);
    strobes(3);
    bus(1'b1, 1'b0, 8'h0C);
    @(negedge clk);
    tick_32k = 1'b1; bus_en = 1'b1; bus_we = 1'b0; bus_port = 1'b1;
    @(negedge clk);
    tick_32k = 1'b0; bus_en = 1'b0;
    check("R9 read returns old flags", bus_rdata, 8'h00);
    check("R9 irq after coincident tick", {7'd0, irq}, 8'h01);
    rd_reg(8'h0C, v); check("R9 tick kept", v, 8'hC0);

    // R12 enable while flag pending
    wr_reg(8'h0B, 8'h00);
    restart(4'h3);
    strobes(4);
    check("R12 irq low while disabled", {7'd0, irq}, 8'h00);
    wr_reg(8'h0B, 8'h40);
    @(negedge clk);
    check("R12 irq after enable", {7'd0, irq}, 8'h01);
    rd_reg(8'h0C, v); check("R12 flags", v, 8'hC0);
    wr_reg(8'h0B, 8'h00);

    // R10 rate change while running (128 Hz to 1024 Hz)
    restart(4'h9);
    strobes(100);
    wr_reg(8'h0A, 8'h26);
    strobes(27);
    rd_reg(8'h0C, v); check("R10 before new tap point", v, 8'h00);
    strobes(1);
    rd_reg(8'h0C, v); check("R10 tick at new tap point", v, 8'h40);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule